// File: doc/BRIEF.md
# Host Bridge Function-0 Configuration Register File

This block holds the 256-byte configuration space of function 0 of a host bridge. Accesses arrive on a byte-wide register port that carries a function number, a byte offset, a write strobe and write data, and the port returns read data combinationally. Every write is filtered before it is stored. Some offsets are read-only. Some registers accept only certain bits. The status byte clears a bit when a one is written to it. One write also copies part of its data into a second register.

Other logic raises status conditions through a set-pulse input. Reset loads the identity bytes, the class code, the base-register type bits and the capability pointer. A compile-time parameter selects between two sets of write masks for the cache and performance control bytes.

Top module: `hbcfg_regfile`

## Requirements
- R1: After reset, offsets 0x00, 0x01, 0x0B, 0x10 and 0x34 read 0x06, 0x11, 0x06, 0x08 and 0xA0. Every other offset reads 0x00.
- R2: A write to an offset in 0x00–0x03, 0x05–0x06, 0x08–0x0C, 0x0E–0x11 or 0x14–0x4F changes no stored byte.
- R3: A write to offset 0x04 stores only bit 6 of the data. The other bits of that byte keep their value.
- R4: In the status byte at offset 0x07, writing 1 to bit 7, 5 or 4 clears that bit. Writing 0 leaves the bit as it was. The remaining bits never change.
- R5: A write to offset 0x0D stores data bits 2:0 there and keeps bits 7:3. In the same edge it copies data bits 2:1 into bits 5:4 of offset 0x75, and the other bits of 0x75 are kept.
- R6: A write to offset 0x12 stores the upper nibble of the data. The lower nibble reads as 0.
- R7: A write to any offset without a specific rule stores the whole byte. This includes 0x13, 0x50 and 0x60 when VARIANT is 0.
- R8: With a function number other than 0, a read returns 0xFF and a write changes nothing.
- R9: Read data follows the stored byte in the same cycle. A write becomes visible only after the next rising clock edge.
- R10: With VARIANT = 1, writes to 0x50, 0x51 and 0x53 store only the bits set in 0xF8, 0xEB and 0xF0 respectively, and keep the other bits.
- R11: A pulse on stat_evt bit 7, 5 or 4 sets that status bit on the next edge. A set wins over a write-one-to-clear of the same bit in the same cycle. Other stat_evt bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_func | input | 3 | Function number of the access |
| acc_addr | input | 8 | Byte offset in configuration space |
| acc_we | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| stat_evt | input | 8 | Status set pulses (bits 7, 5, 4 used) |
| acc_rdata | output | 8 | Read data for acc_func/acc_addr |

## Verification
The hardest case to reach is a status bit being set and cleared in the same cycle. Writes alone can never set a status bit, so the bench first raises bits through stat_evt. It then clears them selectively, and finally drives a set pulse together with a clearing write in one cycle. The mirror into 0x75 is checked after 0x75 has been filled with ones. This shows that only bits 5:4 move. A second instance built with VARIANT = 1 shares the stimulus, so the masked and unmasked writes are compared side by side.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;
    localparam int unsigned CFG_BYTES = 256;
    localparam int unsigned ADDR_W    = $clog2(CFG_BYTES);
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned FUNC_W    = 3;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic [CFG_BYTES-1:0][DATA_W-1:0] mem;
    } cfg_state_t;

    // Offsets whose write behaviour is special
    localparam addr_t OFS_CMD   = 8'h04;
    localparam addr_t OFS_STAT  = 8'h07;
    localparam addr_t OFS_MISC  = 8'h0D;
    localparam addr_t OFS_APBAS = 8'h12;
    localparam addr_t OFS_CCTL1 = 8'h50;
    localparam addr_t OFS_CCTL2 = 8'h51;
    localparam addr_t OFS_PERF  = 8'h53;
    localparam addr_t OFS_MIRR  = 8'h75;

    localparam byte_t CMD_WMASK  = 8'h40;
    localparam byte_t STAT_W1C   = 8'hB0;
    localparam byte_t MISC_WMASK = 8'h07;
    localparam byte_t APB_WMASK  = 8'hF0;
    localparam byte_t MIRR_FIELD = 8'h30;

    // Offsets that refuse every write
    function automatic logic is_ro(input addr_t a);
        return (a <= 8'h03)
            || (a >= 8'h05 && a <= 8'h06)
            || (a >= 8'h08 && a <= 8'h0C)
            || (a >= 8'h0E && a <= 8'h11)
            || (a >= 8'h14 && a <= 8'h4F);
    endfunction

    function automatic byte_t reset_byte(input addr_t a);
        case (a)
            8'h00:   return 8'h06;
            8'h01:   return 8'h11;
            8'h0B:   return 8'h06;
            8'h10:   return 8'h08;
            8'h34:   return 8'hA0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic cfg_state_t reset_state();
        cfg_state_t s;
        for (int i = 0; i < CFG_BYTES; i++) begin
            s.mem[i] = reset_byte(addr_t'(i));
        end
        return s;
    endfunction

    // Plain write mask; variant 1 restricts the control bytes
    function automatic byte_t plain_mask(input addr_t a, input int unsigned variant);
        if (variant == 1) begin
            case (a)
                OFS_CCTL1: return 8'hF8;
                OFS_CCTL2: return 8'hEB;
                OFS_PERF:  return 8'hF0;
                default:   return 8'hFF;
            endcase
        end
        return 8'hFF;
    endfunction
endpackage

// File: rtl/hbcfg_wfilter.sv
module hbcfg_wfilter
    import hbcfg_pkg::*;
#(
    parameter int unsigned VARIANT = 0
) (
    input  addr_t addr,
    input  byte_t old_byte,
    input  byte_t wdata,
    input  byte_t mirr_old,
    output logic  wr_ok,
    output byte_t new_byte,
    output logic  mirr_en,
    output byte_t mirr_new
);
    byte_t mask;

    always_comb begin
        wr_ok    = !is_ro(addr);
        mirr_en  = 1'b0;
        mirr_new = mirr_old;
        mask     = plain_mask(addr, VARIANT);
        new_byte = (old_byte & ~mask) | (wdata & mask);
        case (addr)
            OFS_CMD: begin
                new_byte = (old_byte & ~CMD_WMASK) | (wdata & CMD_WMASK);
            end
            OFS_STAT: begin
                new_byte = old_byte & ~(wdata & STAT_W1C);
            end
            OFS_MISC: begin
                new_byte = (old_byte & ~MISC_WMASK) | (wdata & MISC_WMASK);
                mirr_en  = 1'b1;
                mirr_new = (mirr_old & ~MIRR_FIELD) | {2'b00, wdata[2:1], 4'h0};
            end
            OFS_APBAS: begin
                new_byte = wdata & APB_WMASK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hbcfg_rport.sv
module hbcfg_rport
    import hbcfg_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    input  addr_t             addr,
    input  cfg_state_t        state,
    output byte_t             rdata
);
    always_comb begin
        if (func == '0) begin
            rdata = state.mem[addr];
        end else begin
            rdata = 8'hFF;
        end
    end
endmodule

// File: rtl/hbcfg_regfile.sv
module hbcfg_regfile
    import hbcfg_pkg::*;
#(
    parameter int unsigned VARIANT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FUNC_W-1:0] acc_func,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_we,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] stat_evt,
    output logic [DATA_W-1:0] acc_rdata
);
    localparam cfg_state_t RST_STATE = reset_state();

    cfg_state_t st_d, st_q;
    logic       wr_ok;
    logic       mirr_en;
    byte_t      new_byte;
    byte_t      mirr_new;

    hbcfg_wfilter #(.VARIANT(VARIANT)) u_wfilter (
        .addr     (acc_addr),
        .old_byte (st_q.mem[acc_addr]),
        .wdata    (acc_wdata),
        .mirr_old (st_q.mem[OFS_MIRR]),
        .wr_ok    (wr_ok),
        .new_byte (new_byte),
        .mirr_en  (mirr_en),
        .mirr_new (mirr_new)
    );

    hbcfg_rport u_rport (
        .func  (acc_func),
        .addr  (acc_addr),
        .state (st_q),
        .rdata (acc_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (acc_we && acc_func == '0 && wr_ok) begin
            st_d.mem[acc_addr] = new_byte;
            if (mirr_en) begin
                st_d.mem[OFS_MIRR] = mirr_new;
            end
        end
        // Status set pulses are applied last so they win over a clear
        st_d.mem[OFS_STAT] = st_d.mem[OFS_STAT] | (stat_evt & STAT_W1C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hbcfg_chk.sv
module hbcfg_chk
    import hbcfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [FUNC_W-1:0] acc_func,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_we,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] stat_evt,
    input logic [DATA_W-1:0] acc_rdata,
    input cfg_state_t        st_q
);
    p_reset_ident_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (st_q.mem[0] == 8'h06 && st_q.mem[8'h34] == 8'hA0));

    p_ro_hole_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_func == '0 && is_ro(acc_addr) && stat_evt == '0)
        |=> st_q == $past(st_q));

    p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_func == '0 && acc_addr == OFS_STAT && acc_wdata[7] && !stat_evt[7])
        |=> !st_q.mem[OFS_STAT][7]);

    p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_func == '0 && acc_addr == OFS_MISC)
        |=> st_q.mem[OFS_MIRR][5:4] == $past(acc_wdata[2:1]));

    p_other_func_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_func != '0) |-> acc_rdata == 8'hFF);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_evt[7] |=> st_q.mem[OFS_STAT][7]);
endmodule

bind hbcfg_regfile hbcfg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_func  (acc_func),
    .acc_addr  (acc_addr),
    .acc_we    (acc_we),
    .acc_wdata (acc_wdata),
    .stat_evt  (stat_evt),
    .acc_rdata (acc_rdata),
    .st_q      (st_q)
);

// File: tb/hbcfg_regfile_tb.sv
module hbcfg_regfile_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] acc_func = '0;
    logic [7:0] acc_addr = '0;
    logic       acc_we = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] stat_evt = '0;
    logic [7:0] acc_rdata;
    logic [7:0] alt_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    hbcfg_regfile #(.VARIANT(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_func(acc_func), .acc_addr(acc_addr),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .stat_evt(stat_evt),
        .acc_rdata(acc_rdata)
    );

    hbcfg_regfile #(.VARIANT(1)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .acc_func(acc_func), .acc_addr(acc_addr),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .stat_evt(stat_evt),
        .acc_rdata(alt_rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d,
                      input logic [7:0] ev);
        @(negedge clk);
        acc_func = f; acc_addr = a; acc_wdata = d; acc_we = 1'b1; stat_evt = ev;
        @(negedge clk);
        acc_we = 1'b0; stat_evt = '0; acc_func = '0;
    endtask

    task automatic rd(input logic [2:0] f, input logic [7:0] a, output logic [7:0] d,
                      output logic [7:0] d_alt);
        @(negedge clk);
        acc_func = f; acc_addr = a; acc_we = 1'b0;
        #1;
        d = acc_rdata; d_alt = alt_rdata;
        acc_func = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v, va;
        rd(0, 8'h00, v, va); check("R1 off00", v, 8'h06);
        rd(0, 8'h01, v, va); check("R1 off01", v, 8'h11);
        rd(0, 8'h0B, v, va); check("R1 off0B", v, 8'h06);
        rd(0, 8'h10, v, va); check("R1 off10", v, 8'h08);
        rd(0, 8'h34, v, va); check("R1 off34", v, 8'hA0);
        rd(0, 8'h02, v, va); check("R1 off02", v, 8'h00);
    endtask

    task automatic t_holes();
        logic [7:0] v, va;
        wr(0, 8'h00, 8'hFF, 0); rd(0, 8'h00, v, va); check("R2 off00", v, 8'h06);
        wr(0, 8'h05, 8'hFF, 0); rd(0, 8'h05, v, va); check("R2 off05", v, 8'h00);
        wr(0, 8'h0B, 8'h00, 0); rd(0, 8'h0B, v, va); check("R2 off0B", v, 8'h06);
        wr(0, 8'h11, 8'hFF, 0); rd(0, 8'h11, v, va); check("R2 off11", v, 8'h00);
        wr(0, 8'h34, 8'h00, 0); rd(0, 8'h34, v, va); check("R2 off34", v, 8'hA0);
        wr(0, 8'h4F, 8'hFF, 0); rd(0, 8'h4F, v, va); check("R2 off4F", v, 8'h00);
        wr(0, 8'h13, 8'hC3, 0); rd(0, 8'h13, v, va); check("R7 off13", v, 8'hC3);
    endtask

    task automatic t_cmd();
        logic [7:0] v, va;
        wr(0, 8'h04, 8'hFF, 0); rd(0, 8'h04, v, va); check("R3 set", v, 8'h40);
        wr(0, 8'h04, 8'hBF, 0); rd(0, 8'h04, v, va); check("R3 clr", v, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] v, va;
        wr(0, 8'h60, 8'h00, 8'hFF); rd(0, 8'h07, v, va); check("R11 set", v, 8'hB0);
        wr(0, 8'h07, 8'h80, 0);     rd(0, 8'h07, v, va); check("R4 clr7", v, 8'h30);
        wr(0, 8'h07, 8'h4F, 0);     rd(0, 8'h07, v, va); check("R4 zero", v, 8'h30);
        wr(0, 8'h07, 8'h30, 0);     rd(0, 8'h07, v, va); check("R4 clr54", v, 8'h00);
        wr(0, 8'h07, 8'hB0, 8'h20); rd(0, 8'h07, v, va); check("R11 wins", v, 8'h20);
        wr(0, 8'h07, 8'hFF, 0);     rd(0, 8'h07, v, va); check("R4 all", v, 8'h00);
    endtask

    task automatic t_mirror();
        logic [7:0] v, va;
        wr(0, 8'h75, 8'hFF, 0); rd(0, 8'h75, v, va); check("R7 off75", v, 8'hFF);
        wr(0, 8'h0D, 8'hFA, 0);
        rd(0, 8'h0D, v, va); check("R5 off0D", v, 8'h02);
        rd(0, 8'h75, v, va); check("R5 off75", v, 8'hDF);
        wr(0, 8'h0D, 8'h05, 0);
        rd(0, 8'h75, v, va); check("R5 off75b", v, 8'hEF);
    endtask

    task automatic t_nibble();
        logic [7:0] v, va;
        wr(0, 8'h12, 8'h5A, 0); rd(0, 8'h12, v, va); check("R6 off12", v, 8'h50);
    endtask

    task automatic t_func();
        logic [7:0] v, va;
        wr(1, 8'h61, 8'h77, 0);
        rd(0, 8'h61, v, va); check("R8 nowrite", v, 8'h00);
        rd(1, 8'h00, v, va); check("R8 readff", v, 8'hFF);
        rd(5, 8'h61, v, va); check("R8 readff5", v, 8'hFF);
    endtask

    task automatic t_timing();
        @(negedge clk);
        acc_func = 0; acc_addr = 8'h62; acc_wdata = 8'h3C; acc_we = 1'b1;
        #1;
        check("R9 before", acc_rdata, 8'h00);
        @(posedge clk); #1;
        acc_we = 1'b0;
        check("R9 after", acc_rdata, 8'h3C);
    endtask

    task automatic t_variant();
        logic [7:0] v, va;
        wr(0, 8'h50, 8'hFF, 0); rd(0, 8'h50, v, va);
        check("R7 off50", v, 8'hFF); check("R10 off50", va, 8'hF8);
        wr(0, 8'h51, 8'hFF, 0); rd(0, 8'h51, v, va); check("R10 off51", va, 8'hEB);
        wr(0, 8'h53, 8'hFF, 0); rd(0, 8'h53, v, va); check("R10 off53", va, 8'hF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_holes();
        t_cmd();
        t_status();
        t_mirror();
        t_nibble();
        t_func();
        t_timing();
        t_variant();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule